// File: doc/BRIEF.md
# DDR3 Burst Data Timeslot Scheduler

This block is a behavioural model of the data side of a DDR3 memory. It keeps a circular schedule of future bus timeslots. A read or write command books four consecutive slots that lie a fixed latency ahead. Each slot holds a word address and a direction flag. The ring advances one slot per clock. When a booked slot becomes current, a write beat merges the word on `wrData` into a 32-bit storage array under a per-byte mask. A read beat drives the word that was fetched from storage when the slot was booked.

The block also tracks termination. Each clock it records the on-die-termination input into the slot a few clocks ahead. When the data strobe is driven, the termination must have been on for the current slot and for the previous one, or an error pulse is raised. A second error pulse marks a booking that lands on a slot that is still occupied. Commands arrive already decoded, and the block does not judge whether they are legal.

Top module: `ddr_slot_model`

## Requirements
- R1: With the default write latency of 5, a write command sampled at clock edge k takes beat i (i = 0..3) from `wrData` and `dataMask` sampled at edge k+5+i. The ring position advances by exactly one slot per clock.
- R2: With the default read latency of 5, a read command sampled at edge k presents beat i on `rdData` during the cycle ending at edge k+5+i, provided `busOe` is low.
- R3: Each beat's word address is `((({row, bank, col}) with its 3 low bits cleared) >> 1) + i`, truncated to the storage address width (12 bits by default). The low 3 bits of `col` are therefore ignored.
- R4: For a write beat, `dataMask` bit b covers `wrData[8b+7:8b]`. A set bit keeps the stored byte and a clear bit takes the new byte. A mask of 4'hF leaves storage unchanged.
- R5: Read data is fetched at booking time. A write beat that lands after the read was booked does not change that read's returned data.
- R6: When `busOe` is high, `rdData` equals `wrData`. When `busOe` is low and the current slot is not a read beat, `rdData` is zero.
- R7: A booking where any of its four slots is still occupied raises `collideErr` for the one cycle after the booking edge. The newer command takes the slots. With equal latencies, commands 1 to 3 clocks apart collide and commands 4 or more apart do not.
- R8: The `odt` input is recorded into the slot 2 clocks ahead (write latency minus 3). It is recorded as off while `memResetN` is low. If `dqs` is high at edge w and either the recording made at edge w-2 or the one made at edge w-3 is off, `termErr` is high for the cycle after edge w.
- R9: After a slot has been processed, its used, direction, address, data and termination fields are cleared. A read beat does not reappear when the ring wraps 16 slots later.
- R10: If `cmdRead` and `cmdWrite` are both high, the command is treated as a write.
- R11: After reset, storage reads as zero, the ring is empty, and both error outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the model |
| cmdRead | input | 1 | Decoded read command |
| cmdWrite | input | 1 | Decoded write command |
| bank | input | 3 | Bank of the command |
| row | input | 15 | Open row of the addressed bank |
| col | input | 10 | Column of the command |
| wrData | input | 32 | Write beat data / echoed data |
| dataMask | input | 4 | Per-byte keep mask for write beats |
| odt | input | 1 | Termination enable to record |
| dqs | input | 1 | Data strobe driven by the controller |
| busOe | input | 1 | Controller drives the data bus |
| memResetN | input | 1 | Memory reset pin, active low |
| rdData | output | 32 | Read beat data or echo of `wrData` |
| termErr | output | 1 | Strobe driven without termination (one-cycle pulse) |
| collideErr | output | 1 | Booking hit an occupied slot (one-cycle pulse) |

## Verification
The assertions check several rules on every cycle:
- the ring steps by one slot per clock;
- a processed slot is empty on the following cycle;
- an `odt` sample is present in its lead slot one cycle later;
- a missing previous termination or an occupied booking target raises its error flag;
- an all-ones mask leaves the addressed word untouched.

Only the bench's scenarios can show the rest:
- the absolute beat timing of reads and writes;
- the address packing;
- the byte merge under each of the sixteen masks;
- the capture of read data at booking time;
- the collision window as a function of command spacing;
- the full termination truth table against `memResetN`.

// File: rtl/slot_pkg.sv
package slot_pkg;

  // Strobes passed from the schedule control to the datapath each cycle
  typedef struct packed {
    logic bookEn;     // a command books its beats this cycle
    logic bookRead;   // the booking is a read
    logic procWrite;  // current slot is a write beat
    logic procRead;   // current slot is a read beat
  } strobe_t;

  localparam int BURST_BEATS = 4;

endpackage

// File: rtl/slot_ctrl.sv
module slot_ctrl
  import slot_pkg::*;
#(
  parameter int RING   = 16,
  parameter int RD_LAT = 5,
  parameter int WR_LAT = 5,
  parameter int BEATS  = BURST_BEATS,
  localparam int SW       = $clog2(RING),
  localparam int ODT_LEAD = WR_LAT - 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmdRead,
  input  logic          cmdWrite,
  input  logic          odt,
  input  logic          dqs,
  input  logic          memResetN,
  output strobe_t       strb,
  output logic [SW-1:0] bookSlot,
  output logic [SW-1:0] procSlot,
  output logic          termErr,
  output logic          collideErr
);

  logic [SW-1:0]   posQ;
  logic [RING-1:0] usedQ;
  logic [RING-1:0] readQ;
  logic [RING-1:0] rttQ;
  logic            lastRttQ;

  logic            bookEn;
  logic            bookRd;
  logic [SW-1:0]   odtSlot;
  logic [SW-1:0]   beatSlot [BEATS];
  logic [BEATS-1:0] hitVec;

  // write wins when both commands are present (R10)
  assign bookEn   = cmdRead | cmdWrite;
  assign bookRd   = cmdRead & ~cmdWrite;
  assign bookSlot = posQ + (cmdWrite ? SW'(WR_LAT) : SW'(RD_LAT));
  assign odtSlot  = posQ + SW'(ODT_LEAD);
  assign procSlot = posQ;

  genvar gi;
  generate
    for (gi = 0; gi < BEATS; gi++) begin : gBeat
      assign beatSlot[gi] = bookSlot + SW'(gi);
      assign hitVec[gi]   = usedQ[beatSlot[gi]];
    end
  endgenerate

  always_comb begin
    strb.bookEn    = bookEn;
    strb.bookRead  = bookRd;
    strb.procWrite = usedQ[posQ] & ~readQ[posQ];
    strb.procRead  = usedQ[posQ] & readQ[posQ];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      posQ       <= '0;
      usedQ      <= '0;
      readQ      <= '0;
      rttQ       <= '0;
      lastRttQ   <= 1'b0;
      termErr    <= 1'b0;
      collideErr <= 1'b0;
    end else begin
      posQ       <= posQ + SW'(1);
      lastRttQ   <= rttQ[posQ];
      termErr    <= dqs & ~(rttQ[posQ] & lastRttQ);
      collideErr <= bookEn & (|hitVec);
      // retire the slot that was current this cycle
      usedQ[posQ] <= 1'b0;
      readQ[posQ] <= 1'b0;
      rttQ[posQ]  <= 1'b0;
      // termination is recorded ahead of its data beat
      rttQ[odtSlot] <= odt & memResetN;
      if (bookEn) begin
        for (int i = 0; i < BEATS; i++) begin
          usedQ[beatSlot[i]] <= 1'b1;
          readQ[beatSlot[i]] <= bookRd;
        end
      end
    end
  end

  // R1
  pos_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> posQ == $past(posQ) + SW'(1));

  // R9
  slot_clear_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> !usedQ[$past(posQ)] && !rttQ[$past(posQ)]);

  // R8
  odt_rec_chk: assert property (@(posedge clk) disable iff (rst)
    odt && memResetN |=> rttQ[$past(odtSlot)]);

  // R8
  term_flag_chk: assert property (@(posedge clk) disable iff (rst)
    dqs && !lastRttQ |=> termErr);

  // R7
  collide_flag_chk: assert property (@(posedge clk) disable iff (rst)
    bookEn && usedQ[bookSlot] |=> collideErr);

endmodule

// File: rtl/slot_datapath.sv
module slot_datapath
  import slot_pkg::*;
#(
  parameter int RING   = 16,
  parameter int AW     = 12,
  parameter int DW     = 32,
  parameter int ROW_W  = 15,
  parameter int BANK_W = 3,
  parameter int COL_W  = 10,
  parameter int BEATS  = BURST_BEATS,
  localparam int SW       = $clog2(RING),
  localparam int BYTES    = DW / 8,
  localparam int DEPTH    = 1 << AW,
  localparam int COL_DROP = 3,
  localparam int FULL_W   = ROW_W + BANK_W + COL_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [SW-1:0]     bookSlot,
  input  logic [SW-1:0]     procSlot,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [DW-1:0]     wrData,
  input  logic [BYTES-1:0]  dataMask,
  input  logic              busOe,
  output logic [DW-1:0]     rdData
);

  logic [DW-1:0]     memQ      [DEPTH];
  logic [AW-1:0]     slotAddrQ [RING];
  logic [DW-1:0]     slotDataQ [RING];

  logic [FULL_W-1:0] fullBase;
  logic [AW-1:0]     baseAddr;
  logic [AW-1:0]     beatAddr  [BEATS];
  logic [SW-1:0]     beatSlot  [BEATS];
  logic [AW-1:0]     curAddr;
  logic [DW-1:0]     oldWord;
  logic [DW-1:0]     mergeWord;
  logic              unusedHighBits;

  // packed row/bank/column, burst-aligned, in 32-bit word units (R3)
  assign fullBase       = {row, bank, col[COL_W-1:COL_DROP], {(COL_DROP-1){1'b0}}};
  assign baseAddr       = fullBase[AW-1:0];
  assign unusedHighBits = ^fullBase[FULL_W-1:AW];

  assign curAddr = slotAddrQ[procSlot];
  assign oldWord = memQ[curAddr];

  genvar gi;
  generate
    for (gi = 0; gi < BEATS; gi++) begin : gBeat
      assign beatAddr[gi] = baseAddr + AW'(gi);
      assign beatSlot[gi] = bookSlot + SW'(gi);
    end
    for (gi = 0; gi < BYTES; gi++) begin : gByte
      assign mergeWord[8*gi +: 8] = dataMask[gi] ? oldWord[8*gi +: 8] : wrData[8*gi +: 8];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < DEPTH; a++) memQ[a] <= '0;
      for (int s = 0; s < RING; s++) begin
        slotAddrQ[s] <= '0;
        slotDataQ[s] <= '0;
      end
    end else begin
      if (strb.procWrite && (dataMask != '1)) memQ[curAddr] <= mergeWord;
      slotAddrQ[procSlot] <= '0;
      slotDataQ[procSlot] <= '0;
      if (strb.bookEn) begin
        for (int i = 0; i < BEATS; i++) begin
          slotAddrQ[beatSlot[i]] <= beatAddr[i];
          if (strb.bookRead) slotDataQ[beatSlot[i]] <= memQ[beatAddr[i]];
        end
      end
    end
  end

  always_comb begin
    if (busOe)              rdData = wrData;
    else if (strb.procRead) rdData = slotDataQ[procSlot];
    else                    rdData = '0;
  end

  // R4
  mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
    strb.procWrite && dataMask == '1 |=> memQ[$past(curAddr)] == $past(oldWord));

endmodule

// File: rtl/ddr_slot_model.sv
module ddr_slot_model
  import slot_pkg::*;
#(
  parameter int RING   = 16,
  parameter int RD_LAT = 5,
  parameter int WR_LAT = 5,
  parameter int AW     = 12,
  parameter int DW     = 32,
  parameter int ROW_W  = 15,
  parameter int BANK_W = 3,
  parameter int COL_W  = 10,
  localparam int SW    = $clog2(RING),
  localparam int BYTES = DW / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdRead,
  input  logic              cmdWrite,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [DW-1:0]     wrData,
  input  logic [BYTES-1:0]  dataMask,
  input  logic              odt,
  input  logic              dqs,
  input  logic              busOe,
  input  logic              memResetN,
  output logic [DW-1:0]     rdData,
  output logic              termErr,
  output logic              collideErr
);

  strobe_t       strb;
  logic [SW-1:0] bookSlot;
  logic [SW-1:0] procSlot;

  slot_ctrl #(
    .RING(RING), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT), .BEATS(BURST_BEATS)
  ) uCtrl (
    .clk(clk), .rst(rst), .cmdRead(cmdRead), .cmdWrite(cmdWrite),
    .odt(odt), .dqs(dqs), .memResetN(memResetN),
    .strb(strb), .bookSlot(bookSlot), .procSlot(procSlot),
    .termErr(termErr), .collideErr(collideErr)
  );

  slot_datapath #(
    .RING(RING), .AW(AW), .DW(DW), .ROW_W(ROW_W), .BANK_W(BANK_W),
    .COL_W(COL_W), .BEATS(BURST_BEATS)
  ) uData (
    .clk(clk), .rst(rst), .strb(strb), .bookSlot(bookSlot), .procSlot(procSlot),
    .bank(bank), .row(row), .col(col), .wrData(wrData), .dataMask(dataMask),
    .busOe(busOe), .rdData(rdData)
  );

endmodule

// File: tb/sim_ddr_slot_model.sv
module sim_ddr_slot_model;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmdRead, cmdWrite;
  logic [2:0]  bank;
  logic [14:0] row;
  logic [9:0]  col;
  logic [31:0] wrData;
  logic [3:0]  dataMask;
  logic        odt, dqs, busOe, memResetN;
  logic [31:0] rdData;
  logic        termErr, collideErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [31:0] shadow [4096];

  always #10 clk = ~clk;

  ddr_slot_model u0 (
    .clk(clk), .rst(rst), .cmdRead(cmdRead), .cmdWrite(cmdWrite),
    .bank(bank), .row(row), .col(col), .wrData(wrData), .dataMask(dataMask),
    .odt(odt), .dqs(dqs), .busOe(busOe), .memResetN(memResetN),
    .rdData(rdData), .termErr(termErr), .collideErr(collideErr)
  );

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // next cycle window: inputs set after the falling edge are sampled at the next rising edge
  task automatic nextWin();
    @(negedge clk);
    cmdRead = 1'b0; cmdWrite = 1'b0; wrData = '0; dataMask = 4'hF;
    odt = 1'b0; dqs = 1'b0; busOe = 1'b0; memResetN = 1'b1;
  endtask

  function automatic logic [11:0] wordAddr(input int r, input int b, input int c);
    logic [27:0] w;
    w = {r[14:0], b[2:0], c[9:0]};
    w = (w & ~28'd7) >> 1;
    return w[11:0];
  endfunction

  function automatic logic [31:0] mergeExp(input logic [31:0] oldW, input logic [31:0] newW, input logic [3:0] m);
    logic [31:0] res;
    for (int b = 0; b < 4; b++) res[8*b +: 8] = m[b] ? oldW[8*b +: 8] : newW[8*b +: 8];
    return res;
  endfunction

  task automatic doWrite(input int r, input int b, input int c, input logic [31:0] seed,
                         input logic [3:0] dm, input logic both);
    logic [11:0] a;
    a = wordAddr(r, b, c);
    nextWin(); row = 15'(r); bank = 3'(b); col = 10'(c); cmdWrite = 1'b1; cmdRead = both;
    repeat (4) nextWin();
    for (int i = 0; i < 4; i++) begin
      nextWin(); wrData = seed + 32'(i) * 32'h01010101; dataMask = dm;
      if (dm != 4'hF) shadow[a + 12'(i)] = mergeExp(shadow[a + 12'(i)], wrData, dm);
    end
  endtask

  task automatic doRead(input int r, input int b, input int c, input string tag);
    logic [11:0] a;
    a = wordAddr(r, b, c);
    nextWin(); row = 15'(r); bank = 3'(b); col = 10'(c); cmdRead = 1'b1;
    nextWin(); #1;
    chk(rdData == 32'h0, "R6 idle output", rdData, 32'h0);
    repeat (3) nextWin();
    for (int i = 0; i < 4; i++) begin
      nextWin(); #1;
      chk(rdData == shadow[a + 12'(i)], tag, rdData, shadow[a + 12'(i)]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog (all) actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 4096; i++) shadow[i] = '0;
    rst = 1'b1; row = '0; bank = '0; col = '0;
    cmdRead = 1'b0; cmdWrite = 1'b0; wrData = '0; dataMask = 4'hF;
    odt = 1'b0; dqs = 1'b0; busOe = 1'b0; memResetN = 1'b1;
    repeat (3) @(posedge clk);
    nextWin(); rst = 1'b0; #1;
    // R11 reset state
    chk(rdData == 32'h0, "R11 rdData", rdData, 32'h0);
    chk(termErr == 1'b0, "R11 termErr", 32'(termErr), 32'h0);
    chk(collideErr == 1'b0, "R11 collideErr", 32'(collideErr), 32'h0);
    nextWin(); rst = 1'b0;
    doRead(3, 5, 200, "R11 storage zero");

    // R1 R2 R3: full writes to several packed addresses, low column bits ignored
    doWrite(0, 0, 0, 32'h11223344, 4'h0, 1'b0);
    doWrite(1, 2, 64 + 5, 32'hA0B0C0D0, 4'h0, 1'b0);
    doWrite(7, 7, 1016, 32'h0F1E2D3C, 4'h0, 1'b0);
    doRead(0, 0, 0, "R2 beat data");
    doRead(1, 2, 64, "R3 column low bits");
    doRead(7, 7, 1019, "R1 write timing");

    // R4: every mask value applied over a known word
    for (int m = 0; m < 16; m++) begin
      doWrite(2, 3, 128, 32'hC3C3C3C3, 4'h0, 1'b0);
      doWrite(2, 3, 128, 32'h5A000000 + 32'(m), 4'(m), 1'b0);
      doRead(2, 3, 128, "R4 byte mask");
    end

    // R10: both commands act as a write
    doWrite(0, 6, 512, 32'h77665544, 4'h0, 1'b1);
    doRead(0, 6, 512, "R10 write wins");

    // R5: read booked before write beats land returns old data
    begin
      logic [11:0] a;
      logic [31:0] oldV [4];
      a = wordAddr(0, 0, 0);
      for (int i = 0; i < 4; i++) oldV[i] = shadow[a + 12'(i)];
      nextWin(); row = '0; bank = '0; col = '0; cmdWrite = 1'b1;
      repeat (3) nextWin();
      nextWin(); cmdRead = 1'b1;
      for (int i = 0; i < 4; i++) begin
        nextWin(); wrData = 32'hDEAD0000 + 32'(i); dataMask = 4'h0;
        shadow[a + 12'(i)] = wrData;
      end
      for (int i = 0; i < 4; i++) begin
        nextWin(); #1;
        chk(rdData == oldV[i], "R5 booking capture", rdData, oldV[i]);
      end
      doRead(0, 0, 0, "R5 later read sees write");
    end

    // R6 echo and R9 clearing after wrap
    begin
      logic [11:0] a;
      a = wordAddr(1, 2, 64);
      nextWin(); row = 15'd1; bank = 3'd2; col = 10'd64; cmdRead = 1'b1;
      repeat (4) nextWin();
      nextWin(); #1;
      chk(rdData == shadow[a], "R2 first beat", rdData, shadow[a]);
      nextWin(); busOe = 1'b1; wrData = 32'hA5A55A5A; #1;
      chk(rdData == 32'hA5A55A5A, "R6 echo", rdData, 32'hA5A55A5A);
      repeat (14) nextWin();
      nextWin(); #1;
      chk(rdData == 32'h0, "R9 no repeat after wrap", rdData, 32'h0);
    end

    // R7: collision as a function of command spacing
    for (int g = 1; g <= 5; g++) begin
      repeat (12) nextWin();
      nextWin(); cmdRead = 1'b1;
      for (int j = 1; j <= g; j++) begin
        nextWin();
        if (j == g) cmdRead = 1'b1;
        #1;
        if (j == 1) chk(collideErr == 1'b0, "R7 first booking clean", 32'(collideErr), 32'h0);
      end
      nextWin(); #1;
      chk(collideErr == (g <= 3), "R7 collision spacing", 32'(collideErr), 32'(g <= 3));
    end

    // R8: termination truth table
    repeat (12) nextWin();
    for (int c = 0; c < 16; c++) begin
      logic expE;
      repeat (4) nextWin();
      nextWin(); odt = c[0]; memResetN = c[3];
      nextWin(); odt = c[1]; memResetN = c[3];
      nextWin();
      nextWin(); dqs = c[2]; #1;
      chk(termErr == 1'b0, "R8 quiet before strobe", 32'(termErr), 32'h0);
      nextWin(); #1;
      expE = c[2] & ~(c[0] & c[1] & c[3]);
      chk(termErr == expE, "R8 termination check", 32'(termErr), 32'(expE));
    end

    finishRun();
  end

endmodule